// File: doc/BRIEF.md
# Two-Queue Priority DMA Descriptor Dispatcher

The dispatcher takes transfer descriptors (card-memory byte address, byte count, command byte) from two producers. A stream producer has high priority and a synthesis producer has low priority. Each producer has its own 8-entry queue. The block runs one transfer at a time. For the chosen descriptor it translates the address to the form the downstream engine expects, rounds the count when the data is 16 bits wide, and builds the control byte. It then issues a short series of register writes to the engine over a valid/ready port, one write per clock.

After the control write the block waits for a completion pulse. It then acknowledges the engine by writing zero to the control register and serves the next descriptor, or goes idle when nothing is queued. A descriptor that arrives while the block is idle starts a transfer with no further action from software. A flush discards everything queued and returns the block to idle.

Two static configuration inputs set the address translation. One selects a 16-bit channel. The other selects the enhanced addressing mode, which also adds a high-address write. Both must stay constant while the block is busy.

Top module: `dd_dispatch`

## Requirements
- R1: After reset, `busy`, `wr_valid` and `err_unaligned` are low, and both `hi_ready` and `lo_ready` are high.
- R2: While any high-port descriptor is queued, no low-port descriptor is dispatched. Within each port, descriptors are dispatched in arrival order.
- R3: A descriptor accepted while idle raises `busy` and starts its write series with no other input. `busy` stays high until a completion finds both queues empty, and it then falls.
- R4: `done` is honoured only while the block waits for completion. On the next cycle the block issues an acknowledge write of data 0 to the control register (`wr_sel`=2). Only after that write does it dispatch the next descriptor or go idle.
- R5: With a 16-bit channel in enhanced mode, the word address used is the byte address shifted right by one.
- R6: With a 16-bit channel in legacy mode, a byte address with any of bits [4:0] set is dropped without any write. The drop raises `err_unaligned` for one cycle, and the next queued descriptor is served. An aligned address becomes (bits [19:18] in place) OR (bits [17:0] shifted right by one).
- R7: With an 8-bit channel, the address is used unchanged.
- R8: When the command byte has bit 6 set (16-bit data) or the channel is 16-bit, the count is rounded up to an even value. `xfer_count` holds the count of the transfer in progress.
- R9: The control byte equals the command byte with bit 0 (enable) set, and with bit 2 (channel width) also set for a 16-bit channel.
- R10: The write series is: `wr_sel`=0 with address bits [19:4]; then, only in enhanced mode, `wr_sel`=1 with {address[23:20], address[3:0]} in bits [7:0]; then `wr_sel`=2 with the control byte.
- R11: A flush empties both queues, issues one acknowledge write of 0 to the control register, and leaves the block idle with nothing further dispatched.
- R12: Each queue holds 8 descriptors. While a queue is full its ready is low and a presented descriptor is not accepted; the other port keeps accepting.
- R13: While a write is presented and not accepted, `wr_valid`, `wr_sel` and `wr_data` hold their values; at most one write is issued per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chan16 | input | 1 | Channel is 16 bits wide |
| cfg_enhanced | input | 1 | Enhanced addressing mode |
| hi_valid | input | 1 | High-priority descriptor offered |
| hi_ready | output | 1 | High-priority queue can accept |
| hi_addr | input | 24 | High-priority byte address |
| hi_count | input | 16 | High-priority byte count |
| hi_cmd | input | 8 | High-priority command byte |
| lo_valid | input | 1 | Low-priority descriptor offered |
| lo_ready | output | 1 | Low-priority queue can accept |
| lo_addr | input | 24 | Low-priority byte address |
| lo_count | input | 16 | Low-priority byte count |
| lo_cmd | input | 8 | Low-priority command byte |
| flush | input | 1 | Drop all queued work and go idle |
| wr_valid | output | 1 | Engine register write presented |
| wr_ready | input | 1 | Engine accepts the write |
| wr_sel | output | 2 | Register select: 0 low address, 1 high address, 2 control |
| wr_data | output | 16 | Write data |
| done | input | 1 | Engine completion pulse |
| xfer_count | output | 16 | Adjusted count of the current transfer |
| busy | output | 1 | A transfer is outstanding |
| err_unaligned | output | 1 | One-cycle pulse for a dropped unaligned descriptor |

## Verification
The assertions take for granted that the engine raises `done` only after the control write has been accepted and before any other write. They also assume that a write held by a low `wr_ready` is not cut short by a flush. The stimulus keeps to these rules with a bench engine model. The model arms its completion pulse only when it sees a non-zero control write accepted, and disarms it on an acknowledge write. Flushes are applied only while the block waits for completion, and the configuration inputs change only while `busy` is low.

// File: rtl/dd_pkg.sv
package dd_pkg;
    parameter int unsigned ADDR_W     = 24;
    parameter int unsigned COUNT_W    = 16;
    parameter int unsigned CMD_W      = 8;
    parameter int unsigned DATA_W     = 16;
    parameter int unsigned NUM_Q      = 2;
    parameter int unsigned QDEPTH     = 8;
    parameter int unsigned CTL_EN_BIT  = 0;
    parameter int unsigned CTL_W16_BIT = 2;
    parameter int unsigned CMD_D16_BIT = 6;
    parameter int unsigned LEG_ALIGN_BITS = 5;
    parameter int unsigned LEG_BANK_LSB   = 18;

    localparam int unsigned LO_SHIFT = 4;
    localparam int unsigned HI_NIB_LSB = LO_SHIFT + DATA_W;
    localparam int unsigned Q_IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [COUNT_W-1:0] count;
        logic [CMD_W-1:0]   cmd;
    } desc_t;

    localparam int unsigned DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_CTRL    = 2'd2
    } wsel_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PICK  = 3'd1,
        ST_WLO   = 3'd2,
        ST_WHI   = 3'd3,
        ST_WCTL  = 3'd4,
        ST_WAIT  = 3'd5,
        ST_ACK   = 3'd6,
        ST_FLUSH = 3'd7
    } state_e;

    typedef struct packed {
        state_e             state;
        logic [ADDR_W-1:0]  waddr;
        logic [COUNT_W-1:0] count;
        logic [CMD_W-1:0]   ctrl;
        logic               hi_en;
        logic               err;
    } ctl_t;
endpackage

// File: rtl/dd_fifo.sv
module dd_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [PTR_W:0]   fill;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (p_q.fill != (PTR_W+1)'(DEPTH));
        do_pop  = pop && (p_q.fill != '0);
        p_d     = p_q;
        if (clr) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wr = p_q.wr + PTR_W'(1);
            if (do_pop)  p_d.rd = p_q.rd + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   p_d.fill = p_q.fill + (PTR_W+1)'(1);
                2'b01:   p_d.fill = p_q.fill - (PTR_W+1)'(1);
                default: p_d.fill = p_q.fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[p_q.wr] <= din;
    end

    assign full  = (p_q.fill == (PTR_W+1)'(DEPTH));
    assign empty = (p_q.fill == '0);
    assign dout  = mem_q[p_q.rd];
endmodule

// File: rtl/dd_xlate.sv
module dd_xlate
    import dd_pkg::*;
(
    input  desc_t               desc,
    input  logic                chan16,
    input  logic                enhanced,
    output logic [ADDR_W-1:0]   waddr,
    output logic [COUNT_W-1:0]  count,
    output logic [CMD_W-1:0]    ctrl,
    output logic                reject
);
    logic               round_even;
    logic [COUNT_W-1:0] cnt_inc;

    // Address conversion per channel width and addressing mode.
    always_comb begin
        reject = 1'b0;
        waddr  = desc.addr;
        if (chan16 && enhanced) begin
            waddr = desc.addr >> 1;
        end else if (chan16) begin
            reject = |desc.addr[LEG_ALIGN_BITS-1:0];
            waddr  = '0;
            waddr[LEG_BANK_LSB +: 2]   = desc.addr[LEG_BANK_LSB +: 2];
            waddr[LEG_BANK_LSB-2:0]    = desc.addr[LEG_BANK_LSB-1:1];
        end
    end

    // Count rounding for 16-bit data or 16-bit channels.
    always_comb begin
        round_even = chan16 || desc.cmd[CMD_D16_BIT];
        cnt_inc    = desc.count + COUNT_W'(1);
        count      = round_even ? {cnt_inc[COUNT_W-1:1], 1'b0} : desc.count;
    end

    // Control byte: enable always, channel width for 16-bit channels.
    always_comb begin
        ctrl              = desc.cmd;
        ctrl[CTL_EN_BIT]  = 1'b1;
        if (chan16) ctrl[CTL_W16_BIT] = 1'b1;
    end
endmodule

// File: rtl/dd_dispatch.sv
module dd_dispatch
    import dd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_chan16,
    input  logic                cfg_enhanced,
    input  logic                hi_valid,
    output logic                hi_ready,
    input  logic [ADDR_W-1:0]   hi_addr,
    input  logic [COUNT_W-1:0]  hi_count,
    input  logic [CMD_W-1:0]    hi_cmd,
    input  logic                lo_valid,
    output logic                lo_ready,
    input  logic [ADDR_W-1:0]   lo_addr,
    input  logic [COUNT_W-1:0]  lo_count,
    input  logic [CMD_W-1:0]    lo_cmd,
    input  logic                flush,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [1:0]          wr_sel,
    output logic [DATA_W-1:0]   wr_data,
    input  logic                done,
    output logic [COUNT_W-1:0]  xfer_count,
    output logic                busy,
    output logic                err_unaligned
);
    // Queue 0 is the high-priority stream port, queue 1 the synthesis port.
    logic [DESC_W-1:0] q_din  [NUM_Q];
    logic [DESC_W-1:0] q_head [NUM_Q];
    logic [NUM_Q-1:0]  q_push, q_pop, q_full, q_empty, q_valid;
    logic [Q_IDX_W-1:0] pick_idx;

    desc_t              x_in;
    logic [ADDR_W-1:0]  x_waddr;
    logic [COUNT_W-1:0] x_count;
    logic [CMD_W-1:0]   x_ctrl;
    logic               x_reject;

    ctl_t st_d, st_q;

    assign q_din[0]   = {hi_addr, hi_count, hi_cmd};
    assign q_din[1]   = {lo_addr, lo_count, lo_cmd};
    assign q_valid[0] = hi_valid;
    assign q_valid[1] = lo_valid;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        assign q_push[q] = q_valid[q] && !q_full[q] && !flush;
        dd_fifo #(
            .WIDTH (DESC_W),
            .DEPTH (QDEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (flush),
            .push  (q_push[q]),
            .din   (q_din[q]),
            .full  (q_full[q]),
            .pop   (q_pop[q]),
            .dout  (q_head[q]),
            .empty (q_empty[q])
        );
    end

    assign hi_ready = !q_full[0] && !flush;
    assign lo_ready = !q_full[1] && !flush;

    // Strict priority: lowest-numbered non-empty queue wins.
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (!q_empty[i]) pick_idx = Q_IDX_W'(i);
        end
    end

    assign x_in = desc_t'(q_head[pick_idx]);

    dd_xlate u_xlate (
        .desc     (x_in),
        .chan16   (cfg_chan16),
        .enhanced (cfg_enhanced),
        .waddr    (x_waddr),
        .count    (x_count),
        .ctrl     (x_ctrl),
        .reject   (x_reject)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        q_pop    = '0;
        wr_valid = 1'b0;
        wr_sel   = SEL_CTRL;
        wr_data  = '0;
        case (st_q.state)
            ST_IDLE: begin
                if (q_empty != '1) st_d.state = ST_PICK;
            end
            ST_PICK: begin
                if (q_empty == '1) begin
                    st_d.state = ST_IDLE;
                end else begin
                    q_pop[pick_idx] = 1'b1;
                    if (x_reject) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.waddr = x_waddr;
                        st_d.count = x_count;
                        st_d.ctrl  = x_ctrl;
                        st_d.hi_en = cfg_enhanced;
                        st_d.state = ST_WLO;
                    end
                end
            end
            ST_WLO: begin
                wr_valid = 1'b1;
                wr_sel   = SEL_ADDR_LO;
                wr_data  = st_q.waddr[LO_SHIFT +: DATA_W];
                if (wr_ready) st_d.state = st_q.hi_en ? ST_WHI : ST_WCTL;
            end
            ST_WHI: begin
                wr_valid = 1'b1;
                wr_sel   = SEL_ADDR_HI;
                wr_data  = DATA_W'({st_q.waddr[HI_NIB_LSB +: 4], st_q.waddr[3:0]});
                if (wr_ready) st_d.state = ST_WCTL;
            end
            ST_WCTL: begin
                wr_valid = 1'b1;
                wr_sel   = SEL_CTRL;
                wr_data  = DATA_W'(st_q.ctrl);
                if (wr_ready) st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (done) st_d.state = ST_ACK;
            end
            ST_ACK: begin
                wr_valid = 1'b1;
                wr_sel   = SEL_CTRL;
                if (wr_ready) st_d.state = ST_PICK;
            end
            ST_FLUSH: begin
                wr_valid = 1'b1;
                wr_sel   = SEL_CTRL;
                if (wr_ready) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
        if (flush) begin
            st_d.state = ST_FLUSH;
            q_pop      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy          = (st_q.state != ST_IDLE);
    assign xfer_count    = st_q.count;
    assign err_unaligned = st_q.err;
endmodule

// File: rtl/dd_dispatch_chk.sv
module dd_dispatch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        done,
    input logic        busy,
    input logic        hi_ready,
    input logic        lo_ready,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [1:0]  wr_sel,
    input logic [15:0] wr_data,
    input logic        err_unaligned
);
    assert_wr_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !flush) |=> (wr_valid && $stable(wr_sel) && $stable(wr_data)));

    assert_ack_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flush) |=> (wr_valid && wr_sel == 2'd2 && wr_data == 16'd0));

    assert_done_while_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !wr_valid));

    assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid);

    assert_reject_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_unaligned |-> !wr_valid);

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 !flush) |-> (hi_ready && lo_ready));

    assert_sel_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_sel != 2'd3));
endmodule

bind dd_dispatch dd_dispatch_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .done          (done),
    .busy          (busy),
    .hi_ready      (hi_ready),
    .lo_ready      (lo_ready),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .err_unaligned (err_unaligned)
);

// File: tb/dd_dispatch_tb_top.sv
`timescale 1ns/1ps
module dd_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_chan16 = 1'b0, cfg_enhanced = 1'b0;
    logic        hi_valid = 1'b0, lo_valid = 1'b0;
    logic [23:0] hi_addr = '0, lo_addr = '0;
    logic [15:0] hi_count = '0, lo_count = '0;
    logic [7:0]  hi_cmd = '0, lo_cmd = '0;
    logic        flush = 1'b0, done = 1'b0, wr_ready = 1'b0;
    logic        hi_ready, lo_ready, wr_valid, busy, err_unaligned;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data, xfer_count;

    int n_checks = 0;
    int n_errors = 0;

    // Engine model state, written only by the engine process.
    logic [1:0]  log_sel  [2048];
    logic [15:0] log_data [2048];
    logic [15:0] log_cnt  [2048];
    int log_n = 0;
    int err_n = 0;
    int r13_seen = 0;
    int r13_bad = 0;
    bit hold = 1'b0;

    always #4 clk = ~clk;

    dd_dispatch dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_chan16 (cfg_chan16), .cfg_enhanced (cfg_enhanced),
        .hi_valid (hi_valid), .hi_ready (hi_ready), .hi_addr (hi_addr),
        .hi_count (hi_count), .hi_cmd (hi_cmd),
        .lo_valid (lo_valid), .lo_ready (lo_ready), .lo_addr (lo_addr),
        .lo_count (lo_count), .lo_cmd (lo_cmd),
        .flush (flush), .wr_valid (wr_valid), .wr_ready (wr_ready),
        .wr_sel (wr_sel), .wr_data (wr_data), .done (done),
        .xfer_count (xfer_count), .busy (busy), .err_unaligned (err_unaligned)
    );

    // Engine model: drives ready and completion at the falling edge,
    // samples the port 1 ns before the rising edge.
    initial begin : engine
        logic [7:0] lfsr = 8'hA5;
        bit pend = 1'b0;
        int dly = 0;
        bit prev_stall = 1'b0, prev_flush = 1'b0;
        logic [1:0]  prev_sel = '0;
        logic [15:0] prev_data = '0;
        forever begin
            @(negedge clk);
            done = 1'b0;
            if (pend && !hold) begin
                if (dly == 0) begin done = 1'b1; pend = 1'b0; end
                else dly--;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wr_ready = (lfsr[1:0] != 2'b00);
            #3;
            if (rst_n) begin
                if (prev_stall && !prev_flush) begin
                    r13_seen++;
                    if (!(wr_valid && wr_sel == prev_sel && wr_data == prev_data)) r13_bad++;
                end
                prev_stall = wr_valid && !wr_ready;
                prev_flush = flush;
                prev_sel   = wr_sel;
                prev_data  = wr_data;
                if (wr_valid && wr_ready && log_n < 2048) begin
                    log_sel[log_n]  = wr_sel;
                    log_data[log_n] = wr_data;
                    log_cnt[log_n]  = xfer_count;
                    log_n++;
                    if (wr_sel == 2'd2) begin
                        if (wr_data != 16'd0) begin pend = 1'b1; dly = 2; end
                        else pend = 1'b0;
                    end
                end
                if (err_unaligned) err_n++;
            end
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks + 1, n_errors + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_waddr(input logic [23:0] a, input bit c16, input bit enh);
        if (c16 && enh) return a / 2;
        if (c16) return (a & 24'h0C0000) | ((a & 24'h03FFFF) / 2);
        return a;
    endfunction

    function automatic logic [15:0] exp_count(input logic [15:0] c, input logic [7:0] m, input bit c16);
        if (c16 || m[6]) return (c + 16'd1) & 16'hFFFE;
        return c;
    endfunction

    function automatic logic [7:0] exp_ctrl(input logic [7:0] m, input bit c16);
        return m | 8'h01 | (c16 ? 8'h04 : 8'h00);
    endfunction

    task automatic enqueue(input bit to_hi, input logic [23:0] a, input logic [15:0] c, input logic [7:0] m);
        int guard_n = 0;
        @(negedge clk);
        if (to_hi) begin hi_valid = 1'b1; hi_addr = a; hi_count = c; hi_cmd = m; end
        else       begin lo_valid = 1'b1; lo_addr = a; lo_count = c; lo_cmd = m; end
        #2;
        while (!(to_hi ? hi_ready : lo_ready) && guard_n < 1000) begin
            @(negedge clk); #2; guard_n++;
        end
        @(negedge clk);
        hi_valid = 1'b0;
        lo_valid = 1'b0;
    endtask

    task automatic wait_writes(input int target);
        int t = 0;
        while (log_n < target && t < 400) begin @(negedge clk); t++; end
    endtask

    task automatic wait_idle();
        int t = 0;
        repeat (4) @(negedge clk);
        #2;
        while (busy && t < 400) begin @(negedge clk); #2; t++; end
    endtask

    task automatic run_one(input bit to_hi, input logic [23:0] a, input logic [15:0] c,
                           input logic [7:0] m, input bit c16, input bit enh);
        int base = log_n;
        int eb = err_n;
        int k;
        logic [23:0] wa = exp_waddr(a, c16, enh);
        bit rej = c16 && !enh && (a[4:0] != 5'd0);
        enqueue(to_hi, a, c, m);
        if (rej) begin
            repeat (12) @(negedge clk);
            #2;
            chk(err_n == eb + 1, "R6 reject pulse", 32'(err_n - eb), 32'd1);
            chk(log_n == base, "R6 reject no write", 32'(log_n - base), 32'd0);
            chk(!busy, "R3 idle after reject", 32'(busy), 32'd0);
            return;
        end
        wait_writes(base + (enh ? 4 : 3));
        wait_idle();
        k = base;
        chk(log_sel[k] == 2'd0 && log_data[k] == wa[19:4], "R10 R5 R7 low address write",
            {14'd0, log_sel[k], log_data[k]}, {14'd0, 2'd0, wa[19:4]});
        k++;
        if (enh) begin
            chk(log_sel[k] == 2'd1 && log_data[k] == {8'd0, wa[23:20], wa[3:0]}, "R10 high address write",
                {14'd0, log_sel[k], log_data[k]}, {14'd0, 2'd1, 8'd0, wa[23:20], wa[3:0]});
            k++;
        end
        chk(log_sel[k] == 2'd2 && log_data[k] == {8'd0, exp_ctrl(m, c16)}, "R9 control byte",
            {14'd0, log_sel[k], log_data[k]}, {14'd0, 2'd2, 8'd0, exp_ctrl(m, c16)});
        chk(log_cnt[k] == exp_count(c, m, c16), "R8 count rounding", 32'(log_cnt[k]), 32'(exp_count(c, m, c16)));
        k++;
        chk(log_sel[k] == 2'd2 && log_data[k] == 16'd0, "R4 acknowledge write",
            {14'd0, log_sel[k], log_data[k]}, {14'd0, 2'd2, 16'd0});
        chk(log_n == k + 1, "R10 write count", 32'(log_n - base), 32'(k + 1 - base));
        chk(!busy, "R3 busy falls when queues empty", 32'(busy), 32'd0);
        chk(err_n == eb, "R6 no spurious reject", 32'(err_n - eb), 32'd0);
    endtask

    function automatic logic [23:0] sweep_addr(input int i);
        case (i)
            0: return 24'h000000;
            1: return 24'h000020;
            2: return 24'h0C0040;
            3: return 24'hFEDCA0;
            4: return 24'h123456;
            default: return 24'h3FFFE0;
        endcase
    endfunction

    initial begin : main
        int base, eb, n_lo;
        logic [15:0] lo_seen [8];

        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !wr_valid && !err_unaligned, "R1 reset outputs quiet",
            {29'd0, busy, wr_valid, err_unaligned}, 32'd0);
        chk(hi_ready && lo_ready, "R1 reset ready", {30'd0, hi_ready, lo_ready}, 32'd3);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk(!busy && !wr_valid, "R1 idle after reset", {30'd0, busy, wr_valid}, 32'd0);

        // Sweep: every mode, several addresses, counts and command bytes (R5-R10).
        for (int m = 0; m < 4; m++) begin
            cfg_chan16   = m[1];
            cfg_enhanced = m[0];
            for (int ai = 0; ai < 6; ai++) begin
                run_one(1'b1, sweep_addr(ai), 16'd0,      8'h00, m[1], m[0]);
                run_one(1'b0, sweep_addr(ai), 16'd1,      8'h00, m[1], m[0]);
                run_one(1'b1, sweep_addr(ai), 16'd7,      8'h40, m[1], m[0]);
                run_one(1'b0, sweep_addr(ai), 16'h1235,   8'h42, m[1], m[0]);
            end
        end

        // R2 priority and FIFO order; R3 auto-start of the first one.
        cfg_chan16 = 1'b0; cfg_enhanced = 1'b0;
        hold = 1'b1;
        base = log_n;
        enqueue(1'b0, 24'h000100, 16'd4, 8'h00);
        wait_writes(base + 2);
        chk(busy && log_n == base + 2, "R3 auto-start on enqueue", 32'(log_n - base), 32'd2);
        enqueue(1'b0, 24'h000200, 16'd4, 8'h00);
        enqueue(1'b0, 24'h000300, 16'd4, 8'h00);
        enqueue(1'b1, 24'h000400, 16'd4, 8'h00);
        enqueue(1'b1, 24'h000500, 16'd4, 8'h00);
        chk(busy, "R3 busy held while waiting", 32'(busy), 32'd1);
        hold = 1'b0;
        wait_writes(base + 15);
        wait_idle();
        n_lo = 0;
        for (int i = base; i < log_n; i++) begin
            if (log_sel[i] == 2'd0 && n_lo < 8) begin lo_seen[n_lo] = log_data[i]; n_lo++; end
        end
        chk(n_lo == 5, "R2 dispatch count", 32'(n_lo), 32'd5);
        chk(lo_seen[0] == 16'h0010, "R2 first", 32'(lo_seen[0]), 32'h10);
        chk(lo_seen[1] == 16'h0040, "R2 high before low", 32'(lo_seen[1]), 32'h40);
        chk(lo_seen[2] == 16'h0050, "R2 high order", 32'(lo_seen[2]), 32'h50);
        chk(lo_seen[3] == 16'h0020, "R2 low order", 32'(lo_seen[3]), 32'h20);
        chk(lo_seen[4] == 16'h0030, "R2 low last", 32'(lo_seen[4]), 32'h30);

        // R6: unaligned descriptor between two good ones does not stall.
        cfg_chan16 = 1'b1; cfg_enhanced = 1'b0;
        hold = 1'b1;
        base = log_n;
        eb = err_n;
        enqueue(1'b1, 24'h000040, 16'd2, 8'h00);
        wait_writes(base + 2);
        enqueue(1'b1, 24'h000041, 16'd2, 8'h00);
        enqueue(1'b0, 24'h000080, 16'd2, 8'h00);
        hold = 1'b0;
        wait_writes(base + 6);
        wait_idle();
        chk(log_n == base + 6, "R6 skip keeps going", 32'(log_n - base), 32'd6);
        chk(log_data[base] == 16'h0002, "R6 first aligned", 32'(log_data[base]), 32'h2);
        chk(log_sel[base + 3] == 2'd0 && log_data[base + 3] == 16'h0004, "R6 next after reject",
            32'(log_data[base + 3]), 32'h4);
        chk(err_n == eb + 1, "R6 single error pulse", 32'(err_n - eb), 32'd1);

        // R12 full backpressure and R11 flush.
        cfg_chan16 = 1'b0; cfg_enhanced = 1'b0;
        hold = 1'b1;
        base = log_n;
        enqueue(1'b0, 24'h000900, 16'd4, 8'h00);
        wait_writes(base + 2);
        for (int i = 0; i < 8; i++) enqueue(1'b0, 24'h001000 + 24'(i * 16), 16'd4, 8'h00);
        #2;
        chk(!lo_ready, "R12 full after 8", 32'(lo_ready), 32'd0);
        chk(hi_ready, "R12 other port open", 32'(hi_ready), 32'd1);
        @(negedge clk);
        lo_valid = 1'b1; lo_addr = 24'hABC000; lo_count = 16'd4; lo_cmd = 8'h00;
        repeat (3) @(negedge clk);
        #2;
        chk(!lo_ready, "R12 refused while full", 32'(lo_ready), 32'd0);
        @(negedge clk);
        lo_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        wait_idle();
        chk(log_n == base + 3 && log_sel[base + 2] == 2'd2 && log_data[base + 2] == 16'd0,
            "R11 flush acknowledge", 32'(log_n - base), 32'd3);
        chk(!busy && lo_ready, "R11 idle and empty", {30'd0, busy, lo_ready}, 32'd1);
        hold = 1'b0;
        repeat (30) @(negedge clk);
        chk(log_n == base + 3, "R11 nothing dispatched after flush", 32'(log_n - base), 32'd3);
        run_one(1'b0, 24'h000700, 16'd3, 8'h00, 1'b0, 1'b0);

        chk(r13_seen > 0 && r13_bad == 0, "R13 stalled write held", 32'(r13_bad), 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule